// File: doc/BRIEF.md
# Two-Location Push-Button Light Toggle

This block drives one light from two momentary push buttons placed at different locations. Each complete press of either button inverts the light exactly once. The result does not depend on how long the button is held or on how fast the clock runs.

Each raw button line is active-low. It first passes through a short flip-flop synchronizer and then through a debouncer. The debouncer accepts a new level only after that level has been held for a programmable number of clock cycles. The two cleaned lines are merged into a single "pressed" condition, which feeds a four-state Moore machine. The machine has two idle states (light off, light on) and two held states. A held state traps the machine while any button is down, and the machine leaves it only after both buttons read released. The light output is decoded from the state alone.

Top module: `light_toggle_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released with no press applied, light_o is 0 and both buttons are treated as released.
- R2: Button inputs are active-low: level 1 means released and level 0 means pressed. A raw 0 is seen as a press only after synchronization and debouncing.
- R3: Each debounced press of either button inverts light_o exactly once, from 0 to 1 or from 1 to 0.
- R4: While a debounced press is held, light_o does not change, however long the hold lasts.
- R5: A debounced release (both buttons back at 1) leaves light_o unchanged, and the next press inverts it again.
- R6: A raw level change that lasts fewer than DEBOUNCE_CYCLES consecutive synchronized cycles is ignored and does not change light_o.
- R7: A raw level held steadily is accepted after exactly DEBOUNCE_CYCLES synchronized cycles. With SYNC_STAGES=2, light_o changes on rising edge number DEBOUNCE_CYCLES+3, counting from the first edge that samples the new raw level.
- R8: Pressing both buttons together, or pressing one while the other is still held, counts as a single press event and toggles light_o once.
- R9: Presses that alternate between button A and button B each toggle light_o. Both buttons have equal effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| btn_a_ni | input | 1 | Raw button A, active-low, asynchronous to clk_i |
| btn_b_ni | input | 1 | Raw button B, active-low, asynchronous to clk_i |
| light_o | output | 1 | Light drive, 1 = on |

## Verification
The bench builds the block with DEBOUNCE_CYCLES=8 and SYNC_STAGES=2. This short window lets contact bounce bursts of three cycles, a five-cycle glitch, holds of a few thousand cycles and the exact acceptance latency all fit in a short run. With the window this small, the cycle where light_o changes after DEBOUNCE_CYCLES+3 edges can be checked against a behavioural model every clock. The same setting makes overlapping presses on both buttons and alternating A/B sequences cheap to cover.

// File: rtl/light_toggle_pkg.sv
package light_toggle_pkg;
  typedef enum logic [1:0] {
    ST_OFF_IDLE = 2'd0,
    ST_ON_HELD  = 2'd1,
    ST_ON_IDLE  = 2'd2,
    ST_OFF_HELD = 2'd3
  } lt_state_e;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  // reset to released level (1)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (d_i == lvl_q) begin
      cnt_q <= '0;                  // any return to accepted level restarts
    end else if (cnt_q == CNT_LAST) begin
      cnt_q <= '0;
      lvl_q <= d_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/toggle_fsm.sv
module toggle_fsm
  import light_toggle_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pressed_i,
  output logic light_o
);
  lt_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF_IDLE: if (pressed_i)  st_d = ST_ON_HELD;
      ST_ON_HELD:  if (!pressed_i) st_d = ST_ON_IDLE;
      ST_ON_IDLE:  if (pressed_i)  st_d = ST_OFF_HELD;
      ST_OFF_HELD: if (!pressed_i) st_d = ST_OFF_IDLE;
      default:                     st_d = ST_OFF_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_OFF_IDLE;
    else         st_q <= st_d;
  end

  assign light_o = (st_q == ST_ON_HELD) || (st_q == ST_ON_IDLE);
endmodule

// File: rtl/light_toggle_ctrl.sv
module light_toggle_ctrl #(
  parameter int unsigned DEBOUNCE_CYCLES = 5_000_000,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_a_ni,
  input  logic btn_b_ni,
  output logic light_o
);
  localparam int unsigned NUM_BTN = 2;

  logic [NUM_BTN-1:0] btn_raw;
  logic [NUM_BTN-1:0] btn_sync_lvl;
  logic [NUM_BTN-1:0] btn_deb;
  logic               any_pressed;

  assign btn_raw = {btn_b_ni, btn_a_ni};

  for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
    btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (btn_raw[i]),
      .q_o   (btn_sync_lvl[i])
    );
    btn_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_deb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (btn_sync_lvl[i]),
      .q_o   (btn_deb[i])
    );
  end

  // active-low: any zero is a press
  assign any_pressed = ~&btn_deb;

  toggle_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pressed_i(any_pressed),
    .light_o  (light_o)
  );
endmodule

// File: rtl/light_toggle_chk.sv
module light_toggle_chk #(
  parameter int unsigned DEBOUNCE_CYCLES = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] sync_i,
  input logic [1:0] deb_i,
  input logic       light_i
);
  logic pressed;
  assign pressed = ~&deb_i;

  AST_TOGGLE_ON_PRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pressed) |=> !$stable(light_i)); // R3

  AST_HELD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pressed && $past(pressed) && $past(pressed, 2) |-> $stable(light_i)); // R4

  AST_RELEASED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pressed) |-> $stable(light_i)); // R5

  for (genvar i = 0; i < 2; i++) begin : g_win
    int unsigned run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  run_q <= 0;
      else if (sync_i[i] == deb_i[i]) run_q <= 0;
      else if (run_q < DEBOUNCE_CYCLES + 1) run_q <= run_q + 1;
    end

    AST_DEB_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(deb_i[i]) |-> (run_q >= DEBOUNCE_CYCLES)); // R6
  end
endmodule

bind light_toggle_ctrl light_toggle_chk #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sync_i (btn_sync_lvl),
  .deb_i  (btn_deb),
  .light_i(light_o)
);

// File: tb/tb_light_toggle_ctrl.sv
`timescale 1ns/1ps
module tb_light_toggle_ctrl;
  localparam int DB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] raw = 2'b11;   // [0]=A, [1]=B
  logic light;

  int vectors = 0;
  int miscompares = 0;
  int toggles = 0;
  logic last_light = 1'b0;
  bit   cmp_en = 1'b0;

  // behavioural reference
  logic [1:0] m_s1, m_s2, m_deb;
  int m_cnt [2];
  int m_st;

  always #2 clk = ~clk;

  light_toggle_ctrl #(.DEBOUNCE_CYCLES(DB), .SYNC_STAGES(2)) dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .btn_a_ni(raw[0]),
    .btn_b_ni(raw[1]),
    .light_o (light)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 2'b11; m_s2 = 2'b11; m_deb = 2'b11;
      m_cnt[0] = 0; m_cnt[1] = 0; m_st = 0;
    end else begin
      if      (m_st == 0 && m_deb != 2'b11) m_st = 1;
      else if (m_st == 1 && m_deb == 2'b11) m_st = 2;
      else if (m_st == 2 && m_deb != 2'b11) m_st = 3;
      else if (m_st == 3 && m_deb == 2'b11) m_st = 0;
      for (int i = 0; i < 2; i++) begin
        if (m_s2[i] == m_deb[i]) m_cnt[i] = 0;
        else if (m_cnt[i] == DB - 1) begin m_cnt[i] = 0; m_deb[i] = m_s2[i]; end
        else m_cnt[i] = m_cnt[i] + 1;
      end
      m_s2 = m_s1;
      m_s1 = raw;
    end
  end

  function automatic logic m_light();
    return (m_st == 1 || m_st == 2);
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      vectors++;
      if (light !== m_light()) begin
        miscompares++;
        $display("FAIL R7 t=%0t light_o=%b expected=%b", $time, light, m_light());
      end
      if (light !== last_light) toggles++;
      last_light = light;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bounce(input logic [1:0] mask, input int n);
    for (int k = 0; k < n; k++) begin
      raw = raw & ~mask; idle(3);
      raw = raw | mask;  idle(2);
    end
  endtask

  // one press: bounce, hold, bounce on release, settle
  task automatic press(input logic [1:0] mask, input int hold, input int nb);
    logic held_lvl;
    bounce(mask, nb);
    raw = raw & ~mask;
    idle(DB + 6);
    held_lvl = light;
    idle(hold);
    check("R4 held", int'(light), int'(held_lvl));
    bounce(mask, nb);
    raw = raw | mask;
    idle(DB + 10);
  endtask

  initial begin
    idle(5);
    check("R1 reset light", int'(light), 0);
    rst_n = 1'b1;
    idle(3);
    check("R1 after reset", int'(light), 0);
    cmp_en = 1'b1;
    last_light = light;

    // R7 exact latency on a clean A press
    raw[0] = 1'b0;
    repeat (DB + 2) @(negedge clk);
    check("R7 before latency", int'(light), 0);
    @(negedge clk);
    check("R7 at latency", int'(light), 1);
    idle(20);
    raw[0] = 1'b1;
    idle(DB + 10);
    check("R5 release keeps on", int'(light), 1);
    check("R3 one toggle", toggles, 1);

    // R2 / R3 bouncy press on B turns off
    press(2'b10, 60, 3);
    check("R2 B press off", int'(light), 0);
    check("R3 count", toggles, 2);

    // R6 glitch shorter than window
    raw[0] = 1'b0; idle(DB - 3); raw[0] = 1'b1;
    idle(DB + 10);
    raw[1] = 1'b0; idle(DB - 1); raw[1] = 1'b1;
    idle(DB + 10);
    check("R6 glitch ignored", toggles, 2);
    check("R6 light", int'(light), 0);

    // R4 long hold
    press(2'b01, 2000, 2);
    check("R4 long hold one toggle", toggles, 3);

    // R8 simultaneous
    press(2'b11, 100, 1);
    check("R8 both one toggle", toggles, 4);
    check("R8 light", int'(light), 0);

    // R8 overlapping: A held, B tapped, A released
    raw[0] = 1'b0; idle(DB + 8);
    raw[1] = 1'b0; idle(DB + 20);
    raw[1] = 1'b1; idle(DB + 20);
    raw[0] = 1'b1; idle(DB + 10);
    check("R8 overlap one toggle", toggles, 5);

    // R9 alternating
    for (int n = 0; n < 6; n++) press((n % 2) ? 2'b10 : 2'b01, 30, n % 3);
    check("R9 alternating", toggles, 11);
    check("R9 light", int'(light), 1);

    cmp_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule